// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Condition Flags

This block is the purely combinational execute stage of a small 8-bit RISC core. It takes two byte operands, the stored carry and zero bits from the status register, and a 4-bit operation code. From these it produces an 8-bit result, a 16-bit product for the multiply operation, and next values for six condition flags. Every operation covered here (add, subtract, compare, logic, step, move and unsigned multiply) settles within the same cycle.

Each operation updates its own fixed subset of the flags. The block therefore also drives a per-flag write mask, and a result-write and product-write strobe. The register stage uses these to commit only what the operation touches. Compares run the same subtractor as the subtract operations but raise no write strobe. The borrow-chained compare and subtract keep the previous zero bit whenever their own difference is zero, so a compare or subtract spread across several bytes yields a zero flag that reflects the whole multi-byte value.

The house style centres on a state machine. This block has no states and no transitions: the operation code is decoded by a single `unique case` in one output process.

Top module: `byte_alu`

## Requirements
- R1: Operation codes on `op_sel` are ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, CPC=5, AND=6, OR=7, XOR=8, INC=9, DEC=10, MOV=11, MUL=12. ADD yields a+b and ADC yields a+b+carry_in, each modulo 256. In both, the C flag is the carry out of bit 7.
- R2: SUB yields a−b and SBC yields a−b−carry_in, each modulo 256. C is set when a borrow occurs, that is, when the unsigned subtrahend (including carry) exceeds a.
- R3: CMP and CPC compute the same difference and flags as SUB and SBC respectively, but keep `result_wr` and `product_wr` low.
- R4: Flag vector bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. N is bit 7 of the result, Z is 1 when the result is zero, and S is N XOR V, whenever those flags are written.
- R5: For add, subtract and compare operations, H reports a carry (add) or a borrow (subtract) between bit 3 and bit 4. These operations write all six flags (mask 0x3F).
- R6: For add operations, V is set when both operands have the same sign and the result's sign differs. For subtract and compare operations, V is set when the operand signs differ and the result's sign differs from operand a.
- R7: For SBC and CPC, Z is 0 if the difference is nonzero, and otherwise equals `zero_in`.
- R8: AND, OR and XOR produce the bitwise result, write only Z, N, V and S (mask 0x1E), and force V to 0.
- R9: INC yields a+1 and DEC yields a−1, both ignoring b and carry_in. They write only Z, N, V and S (mask 0x1E). V is set when INC gives 0x80 or DEC gives 0x7F.
- R10: MOV passes b to the result with `result_wr` high and writes no flag (mask 0x00).
- R11: MUL drives the unsigned 16-bit product a×b on `product`, raises `product_wr` with `result_wr` low, and writes only C and Z (mask 0x03). C is bit 15 of the product and Z is 1 when the whole product is zero.
- R12: Codes 13 to 15 raise no write strobe and an all-zero flag mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand, also the destination value |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Stored C flag |
| zero_in | input | 1 | Stored Z flag, used by borrow-chained operations |
| op_sel | input | 4 | Operation code |
| result | output | 8 | Byte result |
| product | output | 16 | Multiply product |
| flag_next | output | 6 | Next flag values (C,Z,N,V,S,H at bits 0..5) |
| flag_wr | output | 6 | Per-flag write mask |
| result_wr | output | 1 | Commit `result` to the destination |
| product_wr | output | 1 | Commit `product` to the register pair |

## Verification
The bound checker holds several relations on every evaluation:
- compares never raise a write strobe;
- move leaves every flag untouched;
- logic operations write exactly Z, N, V and S, with V at 0;
- multiply flags agree with the product;
- the ADD carry and sum agree with the operands;
- S always equals N XOR V when written;
- the two write strobes never rise together.

Only the directed scenarios can show that the behaviour is right for specific operand values. These cover the half-carry and overflow boundaries (0x7F/0x80 crossings, 0x00−0x01), zero-flag chaining against both values of `zero_in`, the immunity of INC and DEC to carry_in, and the silence of the unused codes.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 6;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_CPC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_MOV = 4'd11,
        OP_MUL = 4'd12
    } alu_op_e;

    localparam logic [FLAG_W-1:0] MASK_ALL   = 6'b111111;
    localparam logic [FLAG_W-1:0] MASK_ZNVS  = 6'b011110;
    localparam logic [FLAG_W-1:0] MASK_ZC    = 6'b000011;
    localparam logic [FLAG_W-1:0] MASK_NONE  = 6'b000000;

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             h_out,
    output logic             v_out
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    logic [WIDTH:0] full;
    logic [HALF:0]  low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
        sum   = full[WIDTH-1:0];
        c_out = full[WIDTH];
        h_out = low[HALF];
        if (sub) begin
            v_out = (a[MSB] != b[MSB]) && (full[MSB] != a[MSB]);
        end else begin
            v_out = (a[MSB] == b[MSB]) && (full[MSB] != a[MSB]);
        end
    end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (fn)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/byte_alu_mult.sv
module byte_alu_mult #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [2*WIDTH-1:0] p
);
    localparam int PW = 2 * WIDTH;

    always_comb begin
        p = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, PW[0]};
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic               carry_in,
    input  logic               zero_in,
    input  logic [3:0]         op_sel,
    output logic [WIDTH-1:0]   result,
    output logic [2*WIDTH-1:0] product,
    output logic [FLAG_W-1:0]  flag_next,
    output logic [FLAG_W-1:0]  flag_wr,
    output logic               result_wr,
    output logic               product_wr
);
    localparam int MSB = WIDTH - 1;

    alu_op_e        op;
    logic [WIDTH-1:0] as_b;
    logic             as_cin;
    logic             as_sub;
    logic [WIDTH-1:0] as_sum;
    logic             as_c;
    logic             as_h;
    logic             as_v;
    logic [1:0]       lg_fn;
    logic [WIDTH-1:0] lg_y;
    logic [2*WIDTH-1:0] mul_p;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        as_b   = ((op == OP_INC) || (op == OP_DEC)) ? WIDTH'(1) : opnd_b;
        as_cin = ((op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC)) ? carry_in : 1'b0;
        as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) ||
                 (op == OP_CPC) || (op == OP_DEC);
        lg_fn  = (op == OP_AND) ? 2'd0 : (op == OP_OR) ? 2'd1 : 2'd2;
    end

    byte_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(opnd_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    byte_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(opnd_a), .b(opnd_b), .fn(lg_fn), .y(lg_y)
    );

    byte_alu_mult #(.WIDTH(WIDTH)) u_mult (
        .a(opnd_a), .b(opnd_b), .p(mul_p)
    );

    // single output process: decode the operation code
    always_comb begin
        logic v_bit;
        logic z_bit;
        logic c_bit;
        logic h_bit;
        result     = '0;
        product    = mul_p;
        flag_wr    = MASK_NONE;
        result_wr  = 1'b0;
        product_wr = 1'b0;
        v_bit      = 1'b0;
        c_bit      = 1'b0;
        h_bit      = 1'b0;
        z_bit      = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
                result    = as_sum;
                v_bit     = as_v;
                c_bit     = as_c;
                h_bit     = as_h;
                z_bit     = (as_sum == '0);
                if ((op == OP_SBC) || (op == OP_CPC)) begin
                    z_bit = (as_sum == '0) & zero_in;
                end
                flag_wr   = MASK_ALL;
                result_wr = !((op == OP_CMP) || (op == OP_CPC));
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = lg_y;
                z_bit     = (lg_y == '0);
                flag_wr   = MASK_ZNVS;
                result_wr = 1'b1;
            end
            OP_INC, OP_DEC: begin
                result    = as_sum;
                z_bit     = (as_sum == '0);
                v_bit     = as_v;
                flag_wr   = MASK_ZNVS;
                result_wr = 1'b1;
            end
            OP_MOV: begin
                result    = opnd_b;
                result_wr = 1'b1;
            end
            OP_MUL: begin
                c_bit      = mul_p[2*WIDTH-1];
                z_bit      = (mul_p == '0);
                flag_wr    = MASK_ZC;
                product_wr = 1'b1;
            end
            default: begin
                result = '0;
            end
        endcase
        flag_next       = '0;
        flag_next[FL_C] = c_bit;
        flag_next[FL_Z] = z_bit;
        flag_next[FL_N] = result[MSB];
        flag_next[FL_V] = v_bit;
        flag_next[FL_S] = result[MSB] ^ v_bit;
        flag_next[FL_H] = h_bit;
    end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input logic [WIDTH-1:0]   opnd_a,
    input logic [WIDTH-1:0]   opnd_b,
    input logic               carry_in,
    input logic               zero_in,
    input logic [3:0]         op_sel,
    input logic [WIDTH-1:0]   result,
    input logic [2*WIDTH-1:0] product,
    input logic [FLAG_W-1:0]  flag_next,
    input logic [FLAG_W-1:0]  flag_wr,
    input logic               result_wr,
    input logic               product_wr
);
    logic [WIDTH:0] add_ref;
    assign add_ref = {1'b0, opnd_a} + {1'b0, opnd_b};

    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, carry_in, zero_in})) begin
            if (op_sel == OP_CMP || op_sel == OP_CPC) begin
                AST_CMP_SILENT: assert (!result_wr && !product_wr && flag_wr == MASK_ALL); // R3
            end
            if (op_sel == OP_MOV) begin
                AST_MOV_KEEPS_FLAGS: assert (flag_wr == MASK_NONE && result == opnd_b); // R10
            end
            if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR) begin
                AST_LOGIC_V_LOW: assert (flag_wr == MASK_ZNVS && !flag_next[FL_V]); // R8
            end
            if (op_sel == OP_MUL) begin
                AST_MUL_FLAGS: assert (flag_next[FL_C] == product[2*WIDTH-1] &&
                                       flag_next[FL_Z] == (product == '0) &&
                                       flag_wr == MASK_ZC); // R11
            end
            if (op_sel == OP_ADD) begin
                AST_ADD_SUM: assert ({flag_next[FL_C], result} == add_ref); // R1
            end
            if (flag_wr[FL_S]) begin
                AST_SIGN_RULE: assert (flag_next[FL_S] == (flag_next[FL_N] ^ flag_next[FL_V])); // R4
            end
            AST_ONE_STROBE: assert (!(result_wr && product_wr)); // R11
        end
    end
endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .zero_in(zero_in),
    .op_sel(op_sel), .result(result), .product(product), .flag_next(flag_next),
    .flag_wr(flag_wr), .result_wr(result_wr), .product_wr(product_wr)
);

// File: tb/byte_alu_bench.sv
`timescale 1ns/1ps
module byte_alu_bench;
    logic        clk = 1'b0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic        carry_in = 1'b0;
    logic        zero_in = 1'b0;
    logic [3:0]  op_sel = 4'd15;
    logic [7:0]  result;
    logic [15:0] product;
    logic [5:0]  flag_next;
    logic [5:0]  flag_wr;
    logic        result_wr;
    logic        product_wr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    byte_alu u_byte_alu (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .zero_in(zero_in),
        .op_sel(op_sel), .result(result), .product(product), .flag_next(flag_next),
        .flag_wr(flag_wr), .result_wr(result_wr), .product_wr(product_wr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic z);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; carry_in = c; zero_in = z;
        #1;
    endtask

    // flags are compared only where the mask enables them
    task automatic chk_flags(input string tag, input logic [5:0] mask, input logic [5:0] exp);
        chk({tag, " mask"}, 32'(flag_wr), 32'(mask));
        chk({tag, " flags"}, 32'(flag_next & mask), 32'(exp & mask));
    endtask

    task automatic t_idle;
        for (int k = 13; k < 16; k++) begin
            drive(4'(k), 8'h55, 8'hAA, 1'b1, 1'b1);
            chk("R12 strobes", {30'd0, result_wr, product_wr}, 32'd0);
            chk("R12 mask", 32'(flag_wr), 32'd0);
        end
    endtask

    task automatic t_add;
        drive(4'd0, 8'h13, 8'h5F, 1'b0, 1'b0);
        chk("R1 add sum", 32'(result), 32'h72);
        chk_flags("R5 add h", 6'h3F, 6'b100000);
        drive(4'd0, 8'h80, 8'h80, 1'b1, 1'b0);
        chk("R1 add wrap", 32'(result), 32'h00);
        chk_flags("R6 add v", 6'h3F, 6'b011011);
        drive(4'd1, 8'hFF, 8'h00, 1'b1, 1'b0);
        chk("R1 adc sum", 32'(result), 32'h00);
        chk_flags("R4 adc z", 6'h3F, 6'b100011);
        chk("R1 adc wr", 32'(result_wr), 32'd1);
        // sweep: compare against signed and unsigned integer arithmetic
        for (int a = 0; a < 256; a += 37) begin
            for (int b = 0; b < 256; b += 29) begin
                int us; int ss; logic [5:0] e;
                drive(4'd0, 8'(a), 8'(b), 1'b0, 1'b0);
                us = a + b;
                ss = int'($signed(8'(a))) + int'($signed(8'(b)));
                e = '0;
                e[0] = us > 255;
                e[1] = (us % 256) == 0;
                e[2] = us[7];
                e[3] = (ss > 127) || (ss < -128);
                e[4] = e[2] ^ e[3];
                e[5] = ((a % 16) + (b % 16)) > 15;
                chk("R1 sweep sum", 32'(result), 32'(us % 256));
                chk_flags("R6 sweep", 6'h3F, e);
            end
        end
    endtask

    task automatic t_sub;
        drive(4'd2, 8'h10, 8'h01, 1'b0, 1'b0);
        chk("R2 sub", 32'(result), 32'h0F);
        chk_flags("R5 sub h", 6'h3F, 6'b100000);
        drive(4'd2, 8'h00, 8'h01, 1'b0, 1'b0);
        chk("R2 sub borrow", 32'(result), 32'hFF);
        chk_flags("R2 sub c", 6'h3F, 6'b110101);
        drive(4'd2, 8'h80, 8'h01, 1'b0, 1'b0);
        chk_flags("R6 sub v", 6'h3F, 6'b111000);
        drive(4'd3, 8'h05, 8'h03, 1'b1, 1'b1);
        chk("R2 sbc", 32'(result), 32'h01);
        chk_flags("R7 sbc nz", 6'h3F, 6'b000000);
    endtask

    task automatic t_cmp;
        drive(4'd4, 8'h05, 8'h05, 1'b1, 1'b0);
        chk("R3 cmp strobes", {30'd0, result_wr, product_wr}, 32'd0);
        chk_flags("R3 cmp eq", 6'h3F, 6'b000010);
        drive(4'd5, 8'h12, 8'h11, 1'b1, 1'b1);
        chk_flags("R7 cpc keep z1", 6'h3F, 6'b000010);
        chk("R3 cpc wr", 32'(result_wr), 32'd0);
        drive(4'd5, 8'h12, 8'h11, 1'b1, 1'b0);
        chk_flags("R7 cpc keep z0", 6'h3F, 6'b000000);
        drive(4'd5, 8'h12, 8'h12, 1'b1, 1'b1);
        chk_flags("R7 cpc clear z", 6'h3F, 6'b110101);
    endtask

    task automatic t_logic;
        drive(4'd6, 8'hF0, 8'h3C, 1'b1, 1'b1);
        chk("R8 and", 32'(result), 32'h30);
        chk_flags("R8 and f", 6'h1E, 6'b000000);
        drive(4'd7, 8'h80, 8'h01, 1'b0, 1'b0);
        chk("R8 or", 32'(result), 32'h81);
        chk_flags("R8 or f", 6'h1E, 6'b010100);
        drive(4'd8, 8'hAA, 8'hAA, 1'b0, 1'b0);
        chk("R8 xor", 32'(result), 32'h00);
        chk_flags("R8 xor f", 6'h1E, 6'b000010);
    endtask

    task automatic t_step;
        drive(4'd9, 8'h7F, 8'h33, 1'b1, 1'b0);
        chk("R9 inc", 32'(result), 32'h80);
        chk_flags("R9 inc v", 6'h1E, 6'b001100);
        drive(4'd10, 8'h80, 8'h44, 1'b1, 1'b0);
        chk("R9 dec", 32'(result), 32'h7F);
        chk_flags("R9 dec v", 6'h1E, 6'b011000);
        drive(4'd10, 8'h00, 8'h00, 1'b1, 1'b0);
        chk("R9 dec wrap", 32'(result), 32'hFF);
        chk_flags("R9 dec nv", 6'h1E, 6'b010100);
    endtask

    task automatic t_mov_mul;
        drive(4'd11, 8'h11, 8'h5A, 1'b1, 1'b1);
        chk("R10 mov", 32'(result), 32'h5A);
        chk("R10 mask", 32'(flag_wr), 32'd0);
        chk("R10 wr", 32'(result_wr), 32'd1);
        drive(4'd12, 8'hFF, 8'hFF, 1'b1, 1'b1);
        chk("R11 prod", 32'(product), 32'hFE01);
        chk_flags("R11 mul f", 6'h03, 6'b000001);
        chk("R11 strobes", {30'd0, result_wr, product_wr}, 32'd1);
        drive(4'd12, 8'h00, 8'h33, 1'b0, 1'b0);
        chk("R11 prod zero", 32'(product), 32'h0);
        chk_flags("R11 mul z", 6'h03, 6'b000010);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_idle;
        t_add;
        t_sub;
        t_cmp;
        t_logic;
        t_step;
        t_mov_mul;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule